// File: doc/BRIEF.md
# Injected Conversion Group Sequencer

This block runs the short, high-priority conversion group of a successive-approximation ADC. The group has up to four ranks. Each rank holds its own channel number, sample-time code and offset. A run can start in three ways: a single-cycle software start pulse, a selected edge on one of sixteen external trigger lines, or automatically when the regular group reports that it has finished. The block drives a channel number and sample/convert phase strobes toward the converter core. At the end of each rank's conversion window it captures the raw code, subtracts the rank's offset and keeps one signed result per rank.

The finished results leave on a valid-only stream (`res_valid`, `res_rank`, `res_data`). This stream has no ready signal. The converter cannot be stalled, so back-pressure does not exist: each beat is present for exactly one cycle, and a consumer that misses it reads the same value later from the per-rank store through `rd_rank`/`rd_data`. Configuration arrives through a simple write port. Status and control pins are plain levels or pulses.

Register map (write-only, word address on `cfg_addr`):
- address 0, group control: bits [1:0] hold the rank count minus one; bit 4 turns on scan; bit 5 turns on discontinuous stepping; bit 6 turns on continuous mode; bit 7 turns on auto start; bits [9:8] select the resolution (0 = 12 bit, 1 = 10 bit, 2 = 8 bit, 3 = 6 bit).
- address 1, trigger: bits [1:0] hold the edge mode and bits [7:4] the source line.
- address 2, status: writing bit 0 as 1 clears the sequence-done flag.
- addresses 4 to 7, rank 1 to rank 4: bits [4:0] hold the channel, bits [10:8] the sample code and bits [27:16] the offset.

Top module: `inj_seq_top`

## Requirements
- R1: With scan on, a run converts ranks 1 to N in increasing order, where N is the control field [1:0] plus one. With scan off, a run converts rank 1 only.
- R2: With discontinuous stepping active, each start converts one rank and then moves the rank pointer on by one. After rank N the pointer wraps to rank 1, and only the run that converts rank N sets the sequence-done flag.
- R3: Discontinuous stepping has no effect when scan is off or when continuous mode is on. In those cases a start converts the whole group as in R1.
- R4: A `reg_done` pulse starts a run only when auto start is on, discontinuous stepping is not active and the edge mode is 0. Otherwise the pulse is ignored.
- R5: The edge mode selects the external trigger behaviour: 0 gives no external trigger, 1 triggers on a rising edge, 2 on a falling edge and 3 on both edges. The selected line passes through two synchronising flops. A change applied before clock edge k makes `busy` high after edge k+2.
- R6: Trigger source codes 0 to 10 and 15 are accepted. A trigger write that carries any other source code is ignored as a whole.
- R7: A rank occupies T = S + C cycles. S is 4, 9, 16, 24, 48, 96, 192 or 384 for sample codes 0 to 7. C is 12, 11, 9 or 7 for resolution codes 0 to 3. `adc_sample` is high for the first S cycles and `adc_convert` for the remaining C cycles. `busy` is high for the sum of T over the ranks converted.
- R8: The result equals (raw AND m) minus (offset AND m). Here m is the all-ones mask of the selected resolution. The result is a 13-bit two's-complement value, so it is negative when the raw code is below the offset.
- R9: `res_valid` pulses for one cycle per rank and carries the rank index. `eos` is set after the last rank of a sequence, stays set, and clears only on a write of 1 to status bit 0. After reset `busy`, `eos`, `res_valid` and all stored results are 0.
- R10: Writes to the control and rank registers are ignored while `busy` is high. Trigger register writes take effect at any time.
- R11: A software start, external edge or `reg_done` pulse that arrives while `busy` is high is dropped and is not queued.
- R12: Every accepted write to the control register returns the discontinuous rank pointer to rank 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| sw_start | input | 1 | Software start pulse |
| reg_done | input | 1 | Regular group finished pulse |
| ext_trig | input | 16 | External trigger lines |
| adc_raw | input | 12 | Raw code from the converter core |
| adc_chan | output | 5 | Channel under conversion |
| adc_sample | output | 1 | Sampling phase strobe |
| adc_convert | output | 1 | Conversion phase strobe |
| busy | output | 1 | A run is in progress |
| res_valid | output | 1 | Result beat valid (one cycle) |
| res_rank | output | 2 | Rank of the result beat |
| res_data | output | 13 | Signed offset-corrected result |
| eos | output | 1 | Sticky sequence-done flag |
| rd_rank | input | 2 | Rank selected on the read port |
| rd_data | output | 13 | Stored result of the selected rank |

## Verification
A software start or `reg_done` pulse raises `busy` at the next edge. An external trigger change raises `busy` at the third edge after it is applied. A rank's result beat and stored value appear T cycles after that rank's conversion begins, and the next rank begins on the same edge. The bench drives all inputs at falling edges and samples at falling edges. It counts the falling edges during which `busy` and `adc_sample` are high and compares those counts with the arithmetic window lengths. It reads results only after `busy` has been low for a full cycle. For the trigger path it checks `busy` at exactly the second and third falling edges after the input change.

// File: rtl/inj_pkg.sv
package inj_pkg;
  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_TRIG  = 1;
  localparam int ADDR_STAT  = 2;
  localparam int ADDR_RANK0 = 4;
  localparam int MAX_WINDOW = 384 + 12;

  typedef enum logic [1:0] {
    TRG_NONE = 2'd0,
    TRG_RISE = 2'd1,
    TRG_FALL = 2'd2,
    TRG_BOTH = 2'd3
  } trg_edge_e;

  function automatic int smp_cycles(input logic [2:0] code);
    case (code)
      3'd0: return 4;
      3'd1: return 9;
      3'd2: return 16;
      3'd3: return 24;
      3'd4: return 48;
      3'd5: return 96;
      3'd6: return 192;
      default: return 384;
    endcase
  endfunction

  function automatic int conv_cycles(input logic [1:0] res);
    case (res)
      2'd0: return 12;
      2'd1: return 11;
      2'd2: return 9;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/inj_cfg.sv
module inj_cfg
  import inj_pkg::*;
#(
  parameter int RANKS       = 4,
  parameter int CH_W        = 5,
  parameter int RES_MAX     = 12,
  parameter int SRC_W       = 4,
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 32,
  parameter int SRC_LOW_MAX = 10,
  localparam int RK_W       = $clog2(RANKS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          busy,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [RK_W-1:0]               len_m1,
  output logic                          scan_en,
  output logic                          disc_en,
  output logic                          cont_en,
  output logic                          auto_en,
  output logic [1:0]                    res_sel,
  output logic [1:0]                    edge_sel,
  output logic [SRC_W-1:0]              src_sel,
  output logic [RANKS-1:0][CH_W-1:0]    rank_ch,
  output logic [RANKS-1:0][2:0]         rank_smp,
  output logic [RANKS-1:0][RES_MAX-1:0] rank_off,
  output logic                          ctrl_wr,
  output logic                          eos_clr
);
  logic unused_wdata;
  assign unused_wdata = ^{wdata[DATA_W-1:28], wdata[15:11]};

  function automatic logic src_ok(input logic [SRC_W-1:0] c);
    return (c <= SRC_W'(SRC_LOW_MAX)) || (&c);
  endfunction

  logic trig_wr;
  assign ctrl_wr = we && (addr == ADDR_W'(ADDR_CTRL)) && !busy;
  assign trig_wr = we && (addr == ADDR_W'(ADDR_TRIG)) && src_ok(wdata[4 +: SRC_W]);
  assign eos_clr = we && (addr == ADDR_W'(ADDR_STAT)) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_m1   <= '0;
      scan_en  <= 1'b0;
      disc_en  <= 1'b0;
      cont_en  <= 1'b0;
      auto_en  <= 1'b0;
      res_sel  <= 2'd0;
    end else if (ctrl_wr) begin
      len_m1   <= wdata[RK_W-1:0];
      scan_en  <= wdata[4];
      disc_en  <= wdata[5];
      cont_en  <= wdata[6];
      auto_en  <= wdata[7];
      res_sel  <= wdata[9:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_sel <= 2'd0;
      src_sel  <= '0;
    end else if (trig_wr) begin
      edge_sel <= wdata[1:0];
      src_sel  <= wdata[4 +: SRC_W];
    end
  end

  for (genvar k = 0; k < RANKS; k++) begin : g_rank
    logic hit;
    assign hit = we && !busy && (addr == ADDR_W'(ADDR_RANK0 + k));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rank_ch[k]  <= '0;
        rank_smp[k] <= '0;
        rank_off[k] <= '0;
      end else if (hit) begin
        rank_ch[k]  <= wdata[CH_W-1:0];
        rank_smp[k] <= wdata[10:8];
        rank_off[k] <= wdata[16 +: RES_MAX];
      end
    end
  end
endmodule

// File: rtl/inj_trig.sv
module inj_trig
  import inj_pkg::*;
#(
  parameter int SRC_N = 16,
  localparam int SRC_W = $clog2(SRC_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] ext_trig,
  input  logic [SRC_W-1:0] src_sel,
  input  logic [1:0]       edge_sel,
  input  logic             sw_start,
  input  logic             reg_done,
  input  logic             auto_en,
  input  logic             disc_eff,
  input  logic             busy,
  output logic             start_req
);
  logic [2:0] sh;
  logic       rise, fall, hit, auto_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], ext_trig[src_sel]};
  end

  assign rise = sh[1] & ~sh[2];
  assign fall = ~sh[1] & sh[2];

  always_comb begin
    case (trg_edge_e'(edge_sel))
      TRG_RISE: hit = rise;
      TRG_FALL: hit = fall;
      TRG_BOTH: hit = rise | fall;
      default:  hit = 1'b0;
    endcase
  end

  assign auto_ok   = auto_en && !disc_eff && (trg_edge_e'(edge_sel) == TRG_NONE);
  assign start_req = !busy && (sw_start || hit || (auto_ok && reg_done));
endmodule

// File: rtl/inj_timer.sv
module inj_timer
  import inj_pkg::*;
#(
  parameter int CNT_W = $clog2(MAX_WINDOW + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [2:0] smp_code,
  input  logic [1:0] res_sel,
  output logic       sampling,
  output logic       converting,
  output logic       done
);
  logic             active;
  logic [CNT_W-1:0] cnt, last, smp_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      last   <= '0;
      smp_n  <= '0;
    end else if (go) begin
      active <= 1'b1;
      cnt    <= '0;
      last   <= CNT_W'(smp_cycles(smp_code) + conv_cycles(res_sel) - 1);
      smp_n  <= CNT_W'(smp_cycles(smp_code));
    end else if (active) begin
      if (cnt == last) active <= 1'b0;
      else             cnt    <= cnt + 1'b1;
    end
  end

  assign done       = active && (cnt == last);
  assign sampling   = active && (cnt < smp_n);
  assign converting = active && !sampling;
endmodule

// File: rtl/inj_seq_top.sv
module inj_seq_top
  import inj_pkg::*;
#(
  parameter int CH_W    = 5,
  parameter int RANKS   = 4,
  parameter int RES_MAX = 12,
  parameter int SRC_N   = 16,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32,
  localparam int RK_W   = $clog2(RANKS),
  localparam int SRC_W  = $clog2(SRC_N),
  localparam int RD_W   = RES_MAX + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  input  logic               sw_start,
  input  logic               reg_done,
  input  logic [SRC_N-1:0]   ext_trig,
  input  logic [RES_MAX-1:0] adc_raw,
  output logic [CH_W-1:0]    adc_chan,
  output logic               adc_sample,
  output logic               adc_convert,
  output logic               busy,
  output logic               res_valid,
  output logic [RK_W-1:0]    res_rank,
  output logic [RD_W-1:0]    res_data,
  output logic               eos,
  input  logic [RK_W-1:0]    rd_rank,
  output logic [RD_W-1:0]    rd_data
);
  logic [RK_W-1:0]               len_m1;
  logic                          scan_en, disc_en, cont_en, auto_en;
  logic [1:0]                    res_sel, edge_sel;
  logic [SRC_W-1:0]              trig_src;
  logic [RANKS-1:0][CH_W-1:0]    rank_ch;
  logic [RANKS-1:0][2:0]         rank_smp;
  logic [RANKS-1:0][RES_MAX-1:0] rank_off;
  logic                          ctrl_wr, eos_clr, start_req, conv_done;
  logic                          disc_eff, go, run_end;
  logic [RK_W-1:0]               cur, ptr, nlast, next_rank;
  logic [RES_MAX-1:0]            mask;
  logic [RD_W-1:0]               diff;
  logic [RANKS-1:0][RD_W-1:0]    store;

  inj_cfg #(
    .RANKS(RANKS), .CH_W(CH_W), .RES_MAX(RES_MAX), .SRC_W(SRC_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .busy(busy), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .len_m1(len_m1), .scan_en(scan_en), .disc_en(disc_en),
    .cont_en(cont_en), .auto_en(auto_en), .res_sel(res_sel),
    .edge_sel(edge_sel), .src_sel(trig_src), .rank_ch(rank_ch),
    .rank_smp(rank_smp), .rank_off(rank_off), .ctrl_wr(ctrl_wr),
    .eos_clr(eos_clr)
  );

  assign disc_eff = disc_en && scan_en && !cont_en;
  assign nlast    = scan_en ? len_m1 : '0;

  inj_trig #(.SRC_N(SRC_N)) u_trig (
    .clk(clk), .rst_n(rst_n), .ext_trig(ext_trig), .src_sel(trig_src),
    .edge_sel(edge_sel), .sw_start(sw_start), .reg_done(reg_done),
    .auto_en(auto_en), .disc_eff(disc_eff), .busy(busy),
    .start_req(start_req)
  );

  assign run_end   = conv_done && (disc_eff || (cur == nlast));
  assign go        = start_req || (conv_done && !run_end);
  assign next_rank = start_req ? (disc_eff ? ptr : '0) : RK_W'(cur + 1'b1);

  inj_timer u_timer (
    .clk(clk), .rst_n(rst_n), .go(go), .smp_code(rank_smp[next_rank]),
    .res_sel(res_sel), .sampling(adc_sample), .converting(adc_convert),
    .done(conv_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cur  <= '0;
      ptr  <= '0;
      eos  <= 1'b0;
    end else begin
      if (go) cur <= next_rank;
      if (start_req)    busy <= 1'b1;
      else if (run_end) busy <= 1'b0;
      if (ctrl_wr) ptr <= '0;
      else if (conv_done && disc_eff) ptr <= (cur == nlast) ? '0 : RK_W'(cur + 1'b1);
      else if (conv_done && (cur == nlast)) ptr <= '0;
      if (conv_done && (cur == nlast)) eos <= 1'b1;
      else if (eos_clr)                eos <= 1'b0;
    end
  end

  assign adc_chan = rank_ch[cur];
  assign mask     = {RES_MAX{1'b1}} >> {res_sel, 1'b0};
  assign diff     = {1'b0, adc_raw & mask} - {1'b0, rank_off[cur] & mask};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_rank  <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= conv_done;
      if (conv_done) begin
        res_rank <= cur;
        res_data <= diff;
      end
    end
  end

  for (genvar k = 0; k < RANKS; k++) begin : g_store
    always_ff @(posedge clk) begin
      if (!rst_n)                                  store[k] <= '0;
      else if (conv_done && (cur == RK_W'(k)))     store[k] <= diff;
    end
  end

  assign rd_data = store[rd_rank];
endmodule

// File: rtl/inj_seq_chk.sv
module inj_seq_chk #(
  parameter int CH_W        = 5,
  parameter int RK_W        = 2,
  parameter int SRC_W       = 4,
  parameter int ADDR_W      = 3,
  parameter int SRC_LOW_MAX = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              adc_sample,
  input logic              adc_convert,
  input logic [CH_W-1:0]   adc_chan,
  input logic              res_valid,
  input logic [RK_W-1:0]   res_rank,
  input logic              eos,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic              clr_bit,
  input logic [SRC_W-1:0]  trig_code,
  input logic [RK_W-1:0]   len_m1,
  input logic              scan_en,
  input logic [SRC_W-1:0]  trig_src
);
  logic clr_req, bad_src;
  assign clr_req = cfg_we && (cfg_addr == ADDR_W'(2)) && clr_bit;
  assign bad_src = !((trig_code <= SRC_W'(SRC_LOW_MAX)) || (&trig_code));

  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R9
  AST_PHASE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sample || adc_convert) |-> busy); // R7
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sample |-> !adc_convert); // R7
  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sample && $past(adc_sample)) |-> $stable(adc_chan)); // R1
  AST_RANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_rank <= (scan_en ? len_m1 : '0))); // R1
  AST_EOS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && !clr_req) |=> eos); // R9
  AST_CTRL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_we && (cfg_addr == ADDR_W'(0))) |=> $stable(len_m1)); // R10
  AST_BAD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_addr == ADDR_W'(1)) && bad_src) |=> $stable(trig_src)); // R6
endmodule

bind inj_seq_top inj_seq_chk #(
  .CH_W(CH_W), .RK_W(RK_W), .SRC_W(SRC_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .adc_sample(adc_sample),
  .adc_convert(adc_convert), .adc_chan(adc_chan), .res_valid(res_valid),
  .res_rank(res_rank), .eos(eos), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .clr_bit(cfg_wdata[0]), .trig_code(cfg_wdata[7:4]), .len_m1(len_m1),
  .scan_en(scan_en), .trig_src(trig_src)
);

// File: tb/test_inj_seq_top.sv
`timescale 1ns/1ps
module test_inj_seq_top;
  localparam int CH_W = 5, RK_W = 2, RES_MAX = 12, RD_W = 13, SRC_N = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst_n = 1'b0, cfg_we = 1'b0, sw_start = 1'b0, reg_done = 1'b0;
  logic [2:0]         cfg_addr = '0;
  logic [31:0]        cfg_wdata = '0;
  logic [SRC_N-1:0]   ext_trig = '0;
  logic [RES_MAX-1:0] adc_raw;
  logic [CH_W-1:0]    adc_chan;
  logic               adc_sample, adc_convert, busy, res_valid, eos;
  logic [RK_W-1:0]    res_rank, rd_rank = '0;
  logic [RD_W-1:0]    res_data, rd_data;

  assign adc_raw = RES_MAX'(32'(adc_chan) * 100 + 50);

  inj_seq_top i_inj_seq_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sw_start(sw_start), .reg_done(reg_done),
    .ext_trig(ext_trig), .adc_raw(adc_raw), .adc_chan(adc_chan),
    .adc_sample(adc_sample), .adc_convert(adc_convert), .busy(busy),
    .res_valid(res_valid), .res_rank(res_rank), .res_data(res_data),
    .eos(eos), .rd_rank(rd_rank), .rd_data(rd_data)
  );

  int checks = 0, errors = 0, cyc = 0;
  int ecnt = 0, bcnt = 0, scnt = 0;
  int log_rank [16];
  int log_data [16];

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (ecnt < 16) begin
        log_rank[ecnt] = int'(res_rank);
        log_data[ecnt] = int'($signed(res_data));
      end
      ecnt++;
    end
    if (busy) bcnt++;
    if (adc_sample) scnt++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog (all requirements): cycles %0d expected below 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int tb_smp(input int c);
    case (c)
      0: return 4;   1: return 9;   2: return 16;  3: return 24;
      4: return 48;  5: return 96;  6: return 192; default: return 384;
    endcase
  endfunction

  function automatic int tb_conv(input int r);
    case (r) 0: return 12; 1: return 11; 2: return 9; default: return 7; endcase
  endfunction

  function automatic int exp_res(input int ch, input int off, input int r);
    int m = 12'hFFF >> (2 * r);
    return ((ch * 100 + 50) & m) - (off & m);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 32'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ctrl(input int len_m1, input int scan, input int disc,
                      input int cont, input int auto_on, input int res);
    wr(0, len_m1 | (scan << 4) | (disc << 5) | (cont << 6) | (auto_on << 7) | (res << 8));
  endtask

  task automatic rank(input int k, input int ch, input int smp, input int off);
    wr(4 + k, ch | (smp << 8) | (off << 16));
  endtask

  task automatic trig(input int edge_mode, input int src);
    wr(1, edge_mode | (src << 4));
  endtask

  task automatic clear_logs;
    ecnt = 0; bcnt = 0; scnt = 0;
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic sw_run;
    @(negedge clk);
    clear_logs();
    sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
    wait_idle();
  endtask

  task automatic reg_run;
    @(negedge clk);
    clear_logs();
    reg_done = 1'b1;
    @(negedge clk);
    reg_done = 1'b0;
    wait_idle();
  endtask

  task automatic ext_run(input int idx, input logic val);
    @(negedge clk);
    clear_logs();
    ext_trig[idx] = val;
    repeat (6) @(negedge clk);
    wait_idle();
  endtask

  task automatic read_rank(input int k, output int v);
    rd_rank = RK_W'(k);
    #1;
    v = int'($signed(rd_data));
  endtask

  initial begin
    int v;
    repeat (5) @(negedge clk);
    check("R9 reset busy", int'(busy), 0);
    check("R9 reset eos", int'(eos), 0);
    check("R9 reset res_valid", int'(res_valid), 0);
    read_rank(0, v);
    check("R9 reset store", v, 0);
    rst_n = 1'b1;

    // R7: sweep every resolution and sample code
    for (int r = 0; r < 4; r++) begin
      for (int s = 0; s < 8; s++) begin
        ctrl(0, 0, 0, 0, 0, r);
        rank(0, 5, s, 0);
        sw_run();
        check("R7 busy window", bcnt, tb_smp(s) + tb_conv(r));
        check("R7 sample window", scnt, tb_smp(s));
        check("R7 one beat", ecnt, 1);
      end
    end

    // R8: offset sweep with negative results
    for (int r = 0; r < 4; r++) begin
      foreach (log_rank[i]) log_rank[i] = -1;
      for (int j = 0; j < 5; j++) begin
        int offs [5] = '{0, 550, 551, 4095, 37};
        ctrl(0, 0, 0, 0, 0, r);
        rank(0, 5, 0, offs[j]);
        sw_run();
        check("R8 result beat", log_data[0], exp_res(5, offs[j], r));
        read_rank(0, v);
        check("R8 stored result", v, exp_res(5, offs[j], r));
      end
    end

    // R1: four ranks in order
    ctrl(3, 1, 0, 0, 0, 0);
    rank(0, 3, 0, 0);
    rank(1, 7, 1, 10);
    rank(2, 11, 0, 700);
    rank(3, 20, 2, 3000);
    wr(2, 1);
    sw_run();
    check("R1 beat count", ecnt, 4);
    begin
      int chs [4] = '{3, 7, 11, 20};
      int ofs [4] = '{0, 10, 700, 3000};
      for (int i = 0; i < 4; i++) begin
        check("R1 rank order", log_rank[i], i);
        check("R8 rank data", log_data[i], exp_res(chs[i], ofs[i], 0));
        read_rank(i, v);
        check("R8 rank store", v, exp_res(chs[i], ofs[i], 0));
      end
    end
    check("R7 group busy", bcnt, 16 + 21 + 16 + 28);
    check("R9 eos set", int'(eos), 1);
    wr(2, 0);
    check("R9 eos kept on 0 write", int'(eos), 1);
    wr(2, 1);
    check("R9 eos cleared", int'(eos), 0);

    ctrl(3, 0, 0, 0, 0, 0);
    sw_run();
    check("R1 scan off count", ecnt, 1);
    check("R1 scan off rank", log_rank[0], 0);
    ctrl(1, 1, 0, 0, 0, 0);
    sw_run();
    check("R1 two ranks", ecnt, 2);

    // R2: discontinuous stepping over three ranks
    ctrl(2, 1, 1, 0, 0, 0);
    wr(2, 1);
    for (int i = 0; i < 4; i++) begin
      sw_run();
      check("R2 one rank per start", ecnt, 1);
      check("R2 rank pointer", log_rank[0], i % 3);
      if (i < 3) check("R2 eos after last", int'(eos), (i == 2) ? 1 : 0);
    end
    wr(2, 1);

    // R12: control write resets pointer
    ctrl(2, 1, 1, 0, 0, 0);
    sw_run();
    sw_run();
    check("R12 stepped to rank 2", log_rank[0], 1);
    ctrl(2, 1, 1, 0, 0, 0);
    sw_run();
    check("R12 pointer back to rank 1", log_rank[0], 0);

    // R3: discontinuous ignored
    ctrl(2, 1, 1, 1, 0, 0);
    sw_run();
    check("R3 continuous full group", ecnt, 3);
    ctrl(2, 0, 1, 0, 0, 0);
    sw_run();
    sw_run();
    check("R3 scan off single", ecnt, 1);
    check("R3 scan off rank", log_rank[0], 0);

    // R5: edge modes on source 2
    ctrl(0, 0, 0, 0, 0, 0);
    rank(0, 5, 0, 0);
    trig(1, 2);
    @(negedge clk);
    clear_logs();
    ext_trig[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R5 sync latency low", int'(busy), 0);
    @(negedge clk);
    check("R5 sync latency high", int'(busy), 1);
    wait_idle();
    check("R5 rising runs", ecnt, 1);
    ext_run(2, 1'b0);
    check("R5 rising ignores fall", ecnt, 0);
    trig(2, 2);
    ext_run(2, 1'b1);
    check("R5 falling ignores rise", ecnt, 0);
    ext_run(2, 1'b0);
    check("R5 falling runs", ecnt, 1);
    trig(3, 2);
    ext_run(2, 1'b1);
    check("R5 both rise", ecnt, 1);
    ext_run(2, 1'b0);
    check("R5 both fall", ecnt, 1);
    trig(0, 2);
    ext_run(2, 1'b1);
    check("R5 none rise", ecnt, 0);
    ext_run(2, 1'b0);
    check("R5 none fall", ecnt, 0);

    // R6: source legality
    trig(1, 2);
    trig(1, 12);
    ext_run(12, 1'b1);
    check("R6 illegal source ignored", ecnt, 0);
    ext_run(12, 1'b0);
    ext_run(2, 1'b1);
    check("R6 old source kept", ecnt, 1);
    ext_run(2, 1'b0);
    trig(1, 15);
    ext_run(15, 1'b1);
    check("R6 source 15 accepted", ecnt, 1);
    ext_run(15, 1'b0);

    // R4: automatic start after regular group
    trig(0, 0);
    ctrl(0, 0, 0, 0, 1, 0);
    reg_run();
    check("R4 auto start", ecnt, 1);
    trig(1, 15);
    reg_run();
    check("R4 blocked by edge mode", ecnt, 0);
    trig(0, 0);
    ctrl(1, 1, 1, 0, 1, 0);
    reg_run();
    check("R4 blocked by discontinuous", ecnt, 0);
    ctrl(0, 0, 0, 0, 0, 0);
    reg_run();
    check("R4 auto off", ecnt, 0);

    // R10 and R11: writes and starts during a long run
    rank(0, 5, 7, 0);
    @(negedge clk);
    clear_logs();
    sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
    repeat (3) @(negedge clk);
    ctrl(3, 1, 0, 0, 0, 1);
    rank(0, 9, 0, 100);
    trig(1, 3);
    @(negedge clk);
    sw_start = 1'b1;
    reg_done = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
    reg_done = 1'b0;
    wait_idle();
    repeat (5) @(negedge clk);
    check("R11 start during run dropped", ecnt, 1);
    check("R11 idle after run", int'(busy), 0);
    check("R10 rank write ignored", log_data[0], exp_res(5, 0, 0));
    sw_run();
    check("R10 control write ignored", ecnt, 1);
    check("R10 sample code kept", bcnt, 384 + 12);
    ext_run(3, 1'b1);
    check("R10 trigger write accepted", ecnt, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule